// File: doc/BRIEF.md
# True Color Overlay Mixer

The mixer takes a 32-bit pixel word and splits it into three 8-bit direct color channels and an 8-bit overlay index. The index is ANDed with a read mask, and the result goes out as the address of an external palette that is read synchronously. When that masked value is nonzero, the color returned by the palette replaces the direct color. When it is zero, the direct color passes through unchanged.

The palette answer arrives one clock after its address. The direct color, the overlay decision and the blank and sync controls are therefore held back so that all of them leave together, a fixed number of cycles after they enter. A width select tells the mixer whether each palette channel carries 8 significant bits or only 6. The direct path always carries full 8-bit channels.

Top module: `tc_overlay_mixer`

## Requirements
- R1: Direct color is taken from the pixel word as red = `pix_in[15:8]`, green = `pix_in[23:16]` and blue = `pix_in[31:24]`, and it appears on `red_o`, `grn_o` and `blu_o`.
- R2: `pal_addr` equals `pix_in[7:0] & rd_mask` in the same cycle, with no register in between.
- R3: When `pix_in[7:0] & rd_mask` is zero, the outputs carry the direct color of that pixel. This covers both an all-zero overlay field and a zero mask.
- R4: When `pix_in[7:0] & rd_mask` is nonzero, the outputs carry the palette color for that address. `pal_data` must be valid one cycle after `pal_addr` and is laid out as red `[7:0]`, green `[15:8]` and blue `[23:16]`.
- R5: Color outputs and `blank_o`, `hsync_o` and `vsync_o` all follow their inputs after exactly `PIPE_DEPTH` clock edges (default 2, minimum 2). A stream that changes every cycle keeps each pixel's color paired with its own controls.
- R6: With `pal_6bit` = 1, each palette output channel is that channel's byte bits `[5:0]` shifted left by two, with the lowest two bits zero, and palette bits 7:6 are ignored. With `pal_6bit` = 0, the full palette byte is used.
- R7: `pal_6bit` has no effect on direct color, which always leaves with all 8 bits per channel.
- R8: Reset is synchronous and active high. One edge after reset is sampled high, all color and control outputs are zero, and they stay zero while reset is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 32 | Pixel word: overlay index in the low byte, then red, green, blue |
| blank_in | input | 1 | Blanking control, delayed alongside the pixel |
| hsync_in | input | 1 | Horizontal sync, delayed alongside the pixel |
| vsync_in | input | 1 | Vertical sync, delayed alongside the pixel |
| rd_mask | input | 8 | Read mask ANDed with the overlay index |
| pal_6bit | input | 1 | 1: palette channels hold 6 significant bits; 0: 8 bits |
| pal_addr | output | 8 | Masked overlay index driven to the palette |
| pal_data | input | 24 | Palette color, valid one cycle after pal_addr |
| red_o | output | 8 | Red channel out |
| grn_o | output | 8 | Green channel out |
| blu_o | output | 8 | Blue channel out |
| blank_o | output | 1 | Delayed blanking |
| hsync_o | output | 1 | Delayed horizontal sync |
| vsync_o | output | 1 | Delayed vertical sync |

## Verification
The hardest case to reach from the ports is a stream that changes every cycle, where overlay and direct pixels alternate and the controls toggle, because that is the only way a slip of one stage between the palette path and the direct path can show. The bench drives a new vector on every falling edge. It models the palette as a registered lookup whose contents are computed from the address. Each output is compared with the vector applied exactly `PIPE_DEPTH` cycles earlier. Partial masks that clear some overlay values and keep others, together with palette bytes whose top two bits are set, cover the masking and 6-bit corners.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    localparam int CH_W  = 8;
    localparam int IDX_W = 8;
    localparam int PIX_W = IDX_W + 3 * CH_W;

    typedef struct packed {
        logic [CH_W-1:0] blu;
        logic [CH_W-1:0] grn;
        logic [CH_W-1:0] red;
    } rgb_t;

    typedef struct packed {
        logic blank;
        logic hsync;
        logic vsync;
    } ctrl_t;

    // State carried from the address cycle to the palette-return cycle
    typedef struct packed {
        rgb_t  direct;
        ctrl_t ctrl;
        logic  ovl_on;
        logic  narrow;
    } stage1_t;

    // State carried after the priority choice
    typedef struct packed {
        rgb_t  rgb;
        ctrl_t ctrl;
    } mixed_t;

    function automatic rgb_t split_direct(input logic [PIX_W-1:0] pix);
        rgb_t c;
        c.red = pix[IDX_W +: CH_W];
        c.grn = pix[IDX_W + CH_W +: CH_W];
        c.blu = pix[IDX_W + 2*CH_W +: CH_W];
        return c;
    endfunction

    function automatic logic [CH_W-1:0] fit_channel(input logic [CH_W-1:0] b,
                                                    input logic narrow);
        return narrow ? {b[CH_W-3:0], 2'b00} : b;
    endfunction

    function automatic rgb_t fit_palette(input rgb_t p, input logic narrow);
        rgb_t c;
        c.red = fit_channel(p.red, narrow);
        c.grn = fit_channel(p.grn, narrow);
        c.blu = fit_channel(p.blu, narrow);
        return c;
    endfunction

endpackage

// File: rtl/tcm_field_split.sv
module tcm_field_split
    import tcm_pkg::*;
(
    input  logic [PIX_W-1:0] pix,
    input  logic [IDX_W-1:0] mask,
    output rgb_t             direct,
    output logic [IDX_W-1:0] index,
    output logic             ovl_on
);
    always_comb begin
        direct = split_direct(pix);
        index  = pix[IDX_W-1:0] & mask;
        ovl_on = |index;
    end
endmodule

// File: rtl/tcm_delay.sv
module tcm_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] stg [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
                end
            end
            assign q = stg[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/tcm_prio_sel.sv
module tcm_prio_sel
    import tcm_pkg::*;
(
    input  stage1_t cur,
    input  rgb_t    pal,
    output mixed_t  mixed
);
    always_comb begin
        mixed.ctrl = cur.ctrl;
        mixed.rgb  = cur.ovl_on ? fit_palette(pal, cur.narrow) : cur.direct;
    end
endmodule

// File: rtl/tc_overlay_mixer.sv
module tc_overlay_mixer
    import tcm_pkg::*;
#(
    parameter int PIPE_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             blank_in,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic [IDX_W-1:0] rd_mask,
    input  logic             pal_6bit,
    output logic [IDX_W-1:0] pal_addr,
    input  logic [3*CH_W-1:0] pal_data,
    output logic [CH_W-1:0]  red_o,
    output logic [CH_W-1:0]  grn_o,
    output logic [CH_W-1:0]  blu_o,
    output logic             blank_o,
    output logic             hsync_o,
    output logic             vsync_o
);
    // One stage covers the palette read; the rest follow the choice.
    localparam int TAIL = PIPE_DEPTH - 1;
    localparam int S1_W = $bits(stage1_t);
    localparam int MX_W = $bits(mixed_t);

    rgb_t    direct;
    logic    ovl_on;
    stage1_t s1_d, s1_q;
    mixed_t  mix_d, mix_q;
    rgb_t    pal_rgb;

    tcm_field_split u_split (
        .pix    (pix_in),
        .mask   (rd_mask),
        .direct (direct),
        .index  (pal_addr),
        .ovl_on (ovl_on)
    );

    always_comb begin
        s1_d.direct = direct;
        s1_d.ctrl   = '{blank: blank_in, hsync: hsync_in, vsync: vsync_in};
        s1_d.ovl_on = ovl_on;
        s1_d.narrow = pal_6bit;
    end

    tcm_delay #(.W(S1_W), .DEPTH(1)) u_s1 (
        .clk (clk),
        .rst (rst),
        .d   (s1_d),
        .q   (s1_q)
    );

    assign pal_rgb = rgb_t'(pal_data);

    tcm_prio_sel u_sel (
        .cur   (s1_q),
        .pal   (pal_rgb),
        .mixed (mix_d)
    );

    tcm_delay #(.W(MX_W), .DEPTH(TAIL)) u_tail (
        .clk (clk),
        .rst (rst),
        .d   (mix_d),
        .q   (mix_q)
    );

    assign red_o   = mix_q.rgb.red;
    assign grn_o   = mix_q.rgb.grn;
    assign blu_o   = mix_q.rgb.blu;
    assign blank_o = mix_q.ctrl.blank;
    assign hsync_o = mix_q.ctrl.hsync;
    assign vsync_o = mix_q.ctrl.vsync;
endmodule

// File: rtl/tcm_checker.sv
module tcm_checker
    import tcm_pkg::*;
#(
    parameter int PIPE_DEPTH = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [PIX_W-1:0] pix_in,
    input logic             blank_in,
    input logic             hsync_in,
    input logic             vsync_in,
    input logic [IDX_W-1:0] rd_mask,
    input logic             pal_6bit,
    input logic [IDX_W-1:0] pal_addr,
    input logic [CH_W-1:0]  red_o,
    input logic [CH_W-1:0]  grn_o,
    input logic [CH_W-1:0]  blu_o,
    input logic             blank_o,
    input logic             hsync_o,
    input logic             vsync_o
);
    localparam int LAST = PIPE_DEPTH - 1;

    typedef struct packed {
        logic [3*CH_W-1:0] dir;
        logic [2:0]        ctl;
        logic              on;
        logic              nar;
    } hist_t;

    hist_t hist [PIPE_DEPTH];
    int    fill;
    hist_t now_e;

    always_comb begin
        now_e.dir = pix_in[PIX_W-1:IDX_W];
        now_e.ctl = {blank_in, hsync_in, vsync_in};
        now_e.on  = (pix_in[IDX_W-1:0] & rd_mask) != '0;
        now_e.nar = pal_6bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= 0;
            for (int i = 0; i < PIPE_DEPTH; i++) hist[i] <= '0;
        end else begin
            hist[0] <= now_e;
            for (int i = 1; i < PIPE_DEPTH; i++) hist[i] <= hist[i-1];
            if (fill < PIPE_DEPTH) fill <= fill + 1;
        end
    end

    AST_CTRL_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (fill == PIPE_DEPTH) |-> ({blank_o, hsync_o, vsync_o} == hist[LAST].ctl)); // R5

    AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (rst)
        (fill == PIPE_DEPTH && !hist[LAST].on) |->
            ({blu_o, grn_o, red_o} == hist[LAST].dir)); // R3

    AST_NARROW_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (fill == PIPE_DEPTH && hist[LAST].on && hist[LAST].nar) |->
            (red_o[1:0] == 2'b00 && grn_o[1:0] == 2'b00 && blu_o[1:0] == 2'b00)); // R6

    AST_ADDR_MASK_OFF: assert property (@(posedge clk) disable iff (rst)
        (rd_mask == '0) |-> (pal_addr == '0)); // R2

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> ({red_o, grn_o, blu_o, blank_o, hsync_o, vsync_o} == '0)); // R8
endmodule

bind tc_overlay_mixer tcm_checker #(.PIPE_DEPTH(PIPE_DEPTH)) u_chk (.*);

// File: tb/tb_tc_overlay_mixer.sv
`timescale 1ns/100ps
module tb_tc_overlay_mixer;
    localparam int DEPTH = 2;
    localparam int MAXV  = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] pix_in;
    logic        blank_in, hsync_in, vsync_in;
    logic [7:0]  rd_mask;
    logic        pal_6bit;
    logic [7:0]  pal_addr;
    logic [23:0] pal_data;
    logic [7:0]  red_o, grn_o, blu_o;
    logic        blank_o, hsync_o, vsync_o;

    int vecs  = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0] v_pix  [MAXV];
    logic [2:0]  v_ctl  [MAXV];
    logic [7:0]  v_mask [MAXV];
    logic        v_nar  [MAXV];

    always #2.5 clk = ~clk;

    tc_overlay_mixer #(.PIPE_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .pix_in(pix_in),
        .blank_in(blank_in), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .rd_mask(rd_mask), .pal_6bit(pal_6bit), .pal_addr(pal_addr),
        .pal_data(pal_data), .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o),
        .blank_o(blank_o), .hsync_o(hsync_o), .vsync_o(vsync_o)
    );

    // Palette: {blue, green, red}, top bits often set to expose the 6-bit corner
    function automatic logic [23:0] pal_fn(input logic [7:0] a);
        return {a ^ 8'hC3, ~a, a + 8'h41};
    endfunction

    always_ff @(posedge clk) pal_data <= pal_fn(pal_addr);

    function automatic logic [7:0] fit(input logic [7:0] b, input logic n);
        return n ? {b[5:0], 2'b00} : b;
    endfunction

    // Returns {blue, green, red}
    function automatic logic [23:0] exp_color(input logic [31:0] p,
                                              input logic [7:0] m, input logic n);
        logic [7:0]  a;
        logic [23:0] q;
        a = p[7:0] & m;
        if (a == 8'h00) return {p[31:24], p[23:16], p[15:8]};
        q = pal_fn(a);
        return {fit(q[23:16], n), fit(q[15:8], n), fit(q[7:0], n)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_out(input int k);
        logic [23:0] e;
        logic [7:0]  a;
        string       tag;
        a = v_pix[k][7:0] & v_mask[k];
        e = exp_color(v_pix[k], v_mask[k], v_nar[k]);
        if (a == 8'h00) tag = v_nar[k] ? "R1 R3 R7 direct" : "R1 R3 direct";
        else            tag = v_nar[k] ? "R4 R6 palette narrow" : "R4 R6 palette wide";
        check($sformatf("%s vec%0d", tag, k), {8'h0, blu_o, grn_o, red_o}, {8'h0, e});
        check($sformatf("R5 ctrl vec%0d", k), {29'h0, blank_o, hsync_o, vsync_o},
              {29'h0, v_ctl[k]});
    endtask

    task automatic run_stream(input int n);
        for (int k = 0; k < n + DEPTH; k++) begin
            @(negedge clk);
            if (k >= DEPTH) check_out(k - DEPTH);
            if (k < n) begin
                pix_in   = v_pix[k];
                {blank_in, hsync_in, vsync_in} = v_ctl[k];
                rd_mask  = v_mask[k];
                pal_6bit = v_nar[k];
                #0.5;
                check($sformatf("R2 addr vec%0d", k), {24'h0, pal_addr},
                      {24'h0, v_pix[k][7:0] & v_mask[k]});
            end
        end
    endtask

    task automatic set_v(input int k, input logic [31:0] p, input logic [2:0] c,
                         input logic [7:0] m, input logic n);
        v_pix[k] = p; v_ctl[k] = c; v_mask[k] = m; v_nar[k] = n;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        pix_in = 32'hFFFF_FF11; {blank_in, hsync_in, vsync_in} = 3'b111;
        rd_mask = 8'hFF; pal_6bit = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 reset outputs", {8'h0, red_o, grn_o, blu_o, 5'h0, blank_o, hsync_o, vsync_o}, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_direct();
        set_v(0, 32'h1234_5600, 3'b000, 8'hFF, 1'b0);
        set_v(1, 32'hA5C3_7E00, 3'b101, 8'hFF, 1'b0);
        set_v(2, 32'hFF00_8100, 3'b010, 8'h00, 1'b0);
        run_stream(3);
    endtask

    task automatic t_mask_off();
        set_v(0, 32'h0102_0355, 3'b001, 8'h00, 1'b0);
        set_v(1, 32'h0A0B_0CFF, 3'b100, 8'h00, 1'b1);
        run_stream(2);
    endtask

    task automatic t_overlay_wide();
        set_v(0, 32'h1111_1101, 3'b011, 8'hFF, 1'b0);
        set_v(1, 32'h2222_22FE, 3'b110, 8'hFF, 1'b0);
        set_v(2, 32'h3333_3380, 3'b000, 8'hFF, 1'b0);
        run_stream(3);
    endtask

    task automatic t_partial_mask();
        set_v(0, 32'h4455_66F0, 3'b000, 8'h0F, 1'b0); // masked to zero
        set_v(1, 32'h4455_663C, 3'b111, 8'h0F, 1'b0); // masked to 0C
        set_v(2, 32'h7788_99AA, 3'b010, 8'h55, 1'b0); // masked to 00
        set_v(3, 32'h7788_99AB, 3'b001, 8'h55, 1'b0); // masked to 01
        run_stream(4);
    endtask

    task automatic t_narrow();
        set_v(0, 32'hC0C1_C27F, 3'b000, 8'hFF, 1'b1);
        set_v(1, 32'hFDFE_FF00, 3'b100, 8'hFF, 1'b1); // direct, full 8 bits
        set_v(2, 32'h0000_00C0, 3'b010, 8'hFF, 1'b1);
        set_v(3, 32'h0000_00C0, 3'b001, 8'hFF, 1'b0);
        run_stream(4);
    endtask

    task automatic t_stream_mix();
        for (int k = 0; k < 12; k++) begin
            set_v(k, {8'(k*17), 8'(k*29), 8'(k*7 + 3), (k % 2) ? 8'(k*19 + 1) : 8'h00},
                  3'(k ^ (k >> 1)), (k % 3 == 0) ? 8'h00 : 8'hFF, 1'(k % 4 == 3));
        end
        run_stream(12);
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_direct();
        t_mask_off();
        t_overlay_wide();
        t_partial_mask();
        t_narrow();
        t_stream_mix();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule